// File: doc/BRIEF.md
# Host Register Access Port

This block sits between a microprocessor's bus and the register file of a larger interface. It lets the host read and write the internal registers as ordinary memory locations. The host qualifies every access with a device-select line and an address. Static configuration pins choose the strobe convention and the data width, and the block carries out one register access for each host strobe.

Host strobes arrive asynchronously and pass through a two-flop synchronizer. The block latches the address, and for a write also the data. It then issues one single-cycle read or write strobe to the internal register file. For a read, the block holds the returned value on the host data bus with the output enable set. The completion handshake is given twice, as an active-high ready and an active-low acknowledge. The host stretches its access until it sees either one and must then remove its strobe. The handshake stays up until the block sees the strobe deasserted. It is removed in the cycle after that.

The register file must present read data combinationally, in the same cycle as the read strobe. The block applies no other back-pressure: the host's completion handshake is the only flow control.

Top module: `hostbus_regport`

## Requirements
- R1: After reset, ready is 0, acknowledge is 1 (inactive), the data output enable is 0, and neither register strobe is active.
- R2: A strobe given while device select is high (deselected) produces no register strobe and no handshake.
- R3: With cfg_common_strobe=0, a low host_rd_n starts a read and a low host_wr_n starts a write. host_rnw, host_ds_in_n and host_ds_out_n have no effect.
- R4: With cfg_common_strobe=1, a read happens when host_ds_out_n is low with host_rnw=1, and a write happens when host_ds_in_n is low with host_rnw=0. host_rd_n and host_wr_n have no effect. The two data strobes may be tied together.
- R5: In common-strobe mode, a write needs the input data strobe. host_ds_out_n low with host_rnw=0 and host_ds_in_n high causes no register write and no handshake.
- R6: Each host access produces exactly one reg_rd or reg_wr pulse, one clock wide. A strobe held for many cycles does not repeat it.
- R7: Ready rises only in the cycle after the register strobe, so read data is already on the bus or the write has been issued. host_ack_n is always the inverse of host_rdy.
- R8: The handshake stays asserted while the strobe is held. It drops within a few cycles after the strobe is removed.
- R9: With cfg_wide=1, reg_addr is host_addr[ADDR_W-1:1], reg_be=2'b11, reg_wdata carries the full host word, and reads return the full register word.
- R10: With cfg_wide=0, host_addr[0] selects the byte lane (0 = bits 7:0, 1 = bits 15:8). A write sets only that lane's byte enable (2'b01 or 2'b10) and copies host_data_i[7:0] onto both lanes. A read returns the selected byte in host_data_o[7:0] with bits 15:8 zero.
- R11: host_data_oe is high only during a selected read, from the moment read data is loaded until the handshake drops. It stays low for writes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_common_strobe | input | 1 | 0: separate read/write strobes; 1: direction line plus data strobes |
| cfg_wide | input | 1 | 1: 16-bit host data path; 0: 8-bit |
| host_sel_n | input | 1 | Device select, active low |
| host_addr | input | ADDR_W | Host address |
| host_rd_n | input | 1 | Read strobe (separate mode), active low |
| host_wr_n | input | 1 | Write strobe (separate mode), active low |
| host_rnw | input | 1 | Direction, 1 = read (common mode) |
| host_ds_in_n | input | 1 | Input data strobe for writes (common mode), active low |
| host_ds_out_n | input | 1 | Output data strobe for reads (common mode), active low |
| host_data_i | input | DATA_W | Host write data |
| host_data_o | output | DATA_W | Host read data |
| host_data_oe | output | 1 | Drive enable for the host data bus |
| host_rdy | output | 1 | Completion handshake, active high |
| host_ack_n | output | 1 | Completion handshake, active low |
| reg_addr | output | ADDR_W-1 | Internal register index |
| reg_rd | output | 1 | Single-cycle register read strobe |
| reg_wr | output | 1 | Single-cycle register write strobe |
| reg_wdata | output | DATA_W | Register write data |
| reg_be | output | 2 | Register byte enables |
| reg_rdata | input | DATA_W | Register read data, valid with reg_rd |

## Verification
The bench runs all four combinations of strobe convention and data width. In each one it first writes every host address with address-derived data and then reads every address back. The full-width sweep shows that the register index and the data word pass through unchanged. The byte-wide sweep fills both halves of each register separately, so reading them back shows whether the lane steering and the byte enables are correct. The pins of the unselected convention are driven to their opposite meaning during every access, which shows they have no effect. Deselected strobes and an output strobe given with the direction set to write must leave both the handshake and the register strobes silent.

// File: rtl/hbp_pkg.sv
package hbp_pkg;
  typedef enum logic [1:0] {
    SQ_IDLE  = 2'd0,
    SQ_READ  = 2'd1,
    SQ_WRITE = 2'd2,
    SQ_HOLD  = 2'd3
  } sq_state_e;
endpackage

// File: rtl/hbp_strobe_sync.sv
module hbp_strobe_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic cfg_common_strobe,
  input  logic host_sel_n,
  input  logic host_rd_n,
  input  logic host_wr_n,
  input  logic host_rnw,
  input  logic host_ds_in_n,
  input  logic host_ds_out_n,
  output logic rd_act,
  output logic wr_act
);
  logic raw_rd, raw_wr;
  logic [STAGES-1:0] rd_ff, wr_ff;

  // Write intent in common mode comes only from the input data strobe.
  always_comb begin
    if (cfg_common_strobe) begin
      raw_rd = !host_sel_n && !host_ds_out_n && host_rnw;
      raw_wr = !host_sel_n && !host_ds_in_n && !host_rnw;
    end else begin
      raw_rd = !host_sel_n && !host_rd_n;
      raw_wr = !host_sel_n && !host_wr_n;
    end
  end

  for (genvar g = 0; g < STAGES; g++) begin : g_stage
    if (g == 0) begin : g_first
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          rd_ff[0] <= 1'b0;
          wr_ff[0] <= 1'b0;
        end else begin
          rd_ff[0] <= raw_rd;
          wr_ff[0] <= raw_wr;
        end
      end
    end else begin : g_next
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          rd_ff[g] <= 1'b0;
          wr_ff[g] <= 1'b0;
        end else begin
          rd_ff[g] <= rd_ff[g-1];
          wr_ff[g] <= wr_ff[g-1];
        end
      end
    end
  end

  assign rd_act = rd_ff[STAGES-1];
  assign wr_act = wr_ff[STAGES-1];
endmodule

// File: rtl/hbp_lane_adapt.sv
module hbp_lane_adapt #(
  parameter int ADDR_W = 5,
  parameter int DATA_W = 16
) (
  input  logic              cfg_wide,
  input  logic [ADDR_W-1:0] addr_q,
  input  logic [DATA_W-1:0] wdata_q,
  input  logic [DATA_W-1:0] reg_rdata,
  output logic [ADDR_W-2:0] reg_addr,
  output logic [DATA_W-1:0] reg_wdata,
  output logic [1:0]        reg_be,
  output logic [DATA_W-1:0] lane_rdata
);
  localparam int LANE_W = DATA_W / 2;

  logic hi_lane;
  assign hi_lane  = addr_q[0];
  assign reg_addr = addr_q[ADDR_W-1:1];

  always_comb begin
    if (cfg_wide) begin
      reg_be     = 2'b11;
      reg_wdata  = wdata_q;
      lane_rdata = reg_rdata;
    end else begin
      reg_be     = hi_lane ? 2'b10 : 2'b01;
      reg_wdata  = {wdata_q[LANE_W-1:0], wdata_q[LANE_W-1:0]};
      lane_rdata = {{LANE_W{1'b0}},
                    hi_lane ? reg_rdata[DATA_W-1:LANE_W] : reg_rdata[LANE_W-1:0]};
    end
  end

  // R10: a narrow access touches exactly one byte lane
  always_comb begin
    if (!cfg_wide) begin
      a_r10_one_lane: assert ($countones(reg_be) == 1);
    end
  end
endmodule

// File: rtl/hbp_seq.sv
module hbp_seq
  import hbp_pkg::*;
#(
  parameter int ADDR_W = 5,
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              rd_act,
  input  logic              wr_act,
  input  logic [ADDR_W-1:0] host_addr,
  input  logic [DATA_W-1:0] host_data_i,
  input  logic [DATA_W-1:0] lane_rdata,
  output logic [ADDR_W-1:0] addr_q,
  output logic [DATA_W-1:0] wdata_q,
  output logic              reg_rd,
  output logic              reg_wr,
  output logic [DATA_W-1:0] bus_data,
  output logic              bus_oe,
  output logic              rdy
);
  sq_state_e state;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state    <= SQ_IDLE;
      addr_q   <= '0;
      wdata_q  <= '0;
      bus_data <= '0;
      bus_oe   <= 1'b0;
      rdy      <= 1'b0;
    end else begin
      case (state)
        SQ_IDLE: begin
          if (rd_act) begin
            addr_q <= host_addr;
            state  <= SQ_READ;
          end else if (wr_act) begin
            addr_q  <= host_addr;
            wdata_q <= host_data_i;
            state   <= SQ_WRITE;
          end
        end
        SQ_READ: begin
          bus_data <= lane_rdata;
          bus_oe   <= 1'b1;
          rdy      <= 1'b1;
          state    <= SQ_HOLD;
        end
        SQ_WRITE: begin
          rdy   <= 1'b1;
          state <= SQ_HOLD;
        end
        default: begin
          if (!rd_act && !wr_act) begin
            rdy    <= 1'b0;
            bus_oe <= 1'b0;
            state  <= SQ_IDLE;
          end
        end
      endcase
    end
  end

  assign reg_rd = (state == SQ_READ);
  assign reg_wr = (state == SQ_WRITE);

  a_r6_rd_single: assert property (@(posedge clk) disable iff (!rst_n)
    reg_rd |=> !reg_rd);
  a_r6_wr_single: assert property (@(posedge clk) disable iff (!rst_n)
    reg_wr |=> !reg_wr);
  a_r7_rdy_follows_strobe: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rdy) |-> ($past(reg_rd) || $past(reg_wr)));
  a_r8_rdy_held: assert property (@(posedge clk) disable iff (!rst_n)
    (rdy && (rd_act || wr_act)) |=> rdy);
  a_r11_oe_in_read: assert property (@(posedge clk) disable iff (!rst_n)
    bus_oe |-> rdy);
endmodule

// File: rtl/hostbus_regport.sv
module hostbus_regport #(
  parameter int ADDR_W      = 5,
  parameter int DATA_W      = 16,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_common_strobe,
  input  logic              cfg_wide,
  input  logic              host_sel_n,
  input  logic [ADDR_W-1:0] host_addr,
  input  logic              host_rd_n,
  input  logic              host_wr_n,
  input  logic              host_rnw,
  input  logic              host_ds_in_n,
  input  logic              host_ds_out_n,
  input  logic [DATA_W-1:0] host_data_i,
  output logic [DATA_W-1:0] host_data_o,
  output logic              host_data_oe,
  output logic              host_rdy,
  output logic              host_ack_n,
  output logic [ADDR_W-2:0] reg_addr,
  output logic              reg_rd,
  output logic              reg_wr,
  output logic [DATA_W-1:0] reg_wdata,
  output logic [1:0]        reg_be,
  input  logic [DATA_W-1:0] reg_rdata
);
  logic              rd_act, wr_act;
  logic [ADDR_W-1:0] addr_q;
  logic [DATA_W-1:0] wdata_q;
  logic [DATA_W-1:0] lane_rdata;
  logic              rdy;

  hbp_strobe_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk               (clk),
    .rst_n             (rst_n),
    .cfg_common_strobe (cfg_common_strobe),
    .host_sel_n        (host_sel_n),
    .host_rd_n         (host_rd_n),
    .host_wr_n         (host_wr_n),
    .host_rnw          (host_rnw),
    .host_ds_in_n      (host_ds_in_n),
    .host_ds_out_n     (host_ds_out_n),
    .rd_act            (rd_act),
    .wr_act            (wr_act)
  );

  hbp_seq #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_seq (
    .clk         (clk),
    .rst_n       (rst_n),
    .rd_act      (rd_act),
    .wr_act      (wr_act),
    .host_addr   (host_addr),
    .host_data_i (host_data_i),
    .lane_rdata  (lane_rdata),
    .addr_q      (addr_q),
    .wdata_q     (wdata_q),
    .reg_rd      (reg_rd),
    .reg_wr      (reg_wr),
    .bus_data    (host_data_o),
    .bus_oe      (host_data_oe),
    .rdy         (rdy)
  );

  hbp_lane_adapt #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_lane (
    .cfg_wide   (cfg_wide),
    .addr_q     (addr_q),
    .wdata_q    (wdata_q),
    .reg_rdata  (reg_rdata),
    .reg_addr   (reg_addr),
    .reg_wdata  (reg_wdata),
    .reg_be     (reg_be),
    .lane_rdata (lane_rdata)
  );

  assign host_rdy   = rdy;
  assign host_ack_n = !rdy;
endmodule

// File: tb/hostbus_regport_tb_top.sv
module hostbus_regport_tb_top;
  localparam int ADDR_W = 5;
  localparam int DATA_W = 16;
  localparam int NREG   = 1 << (ADDR_W - 1);

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic              cfg_common_strobe = 1'b0;
  logic              cfg_wide = 1'b1;
  logic              host_sel_n = 1'b1;
  logic [ADDR_W-1:0] host_addr = '0;
  logic              host_rd_n = 1'b1;
  logic              host_wr_n = 1'b1;
  logic              host_rnw = 1'b1;
  logic              host_ds_in_n = 1'b1;
  logic              host_ds_out_n = 1'b1;
  logic [DATA_W-1:0] host_data_i = '0;
  logic [DATA_W-1:0] host_data_o;
  logic              host_data_oe, host_rdy, host_ack_n;
  logic [ADDR_W-2:0] reg_addr;
  logic              reg_rd, reg_wr;
  logic [DATA_W-1:0] reg_wdata;
  logic [1:0]        reg_be;
  logic [DATA_W-1:0] reg_rdata;

  logic [DATA_W-1:0] mem    [NREG];
  logic [DATA_W-1:0] shadow [NREG];
  int checks = 0;
  int errors = 0;
  int rd_pulses = 0;
  int wr_pulses = 0;
  int cycles = 0;

  always #2 clk = !clk;

  hostbus_regport #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) dut_i (
    .clk(clk), .rst_n(rst_n), .cfg_common_strobe(cfg_common_strobe),
    .cfg_wide(cfg_wide), .host_sel_n(host_sel_n), .host_addr(host_addr),
    .host_rd_n(host_rd_n), .host_wr_n(host_wr_n), .host_rnw(host_rnw),
    .host_ds_in_n(host_ds_in_n), .host_ds_out_n(host_ds_out_n),
    .host_data_i(host_data_i), .host_data_o(host_data_o),
    .host_data_oe(host_data_oe), .host_rdy(host_rdy), .host_ack_n(host_ack_n),
    .reg_addr(reg_addr), .reg_rd(reg_rd), .reg_wr(reg_wr),
    .reg_wdata(reg_wdata), .reg_be(reg_be), .reg_rdata(reg_rdata)
  );

  // Register file model on the internal side
  assign reg_rdata = mem[reg_addr];
  always @(posedge clk) begin
    cycles <= cycles + 1;
    if (reg_rd) rd_pulses <= rd_pulses + 1;
    if (reg_wr) begin
      wr_pulses <= wr_pulses + 1;
      if (reg_be[0]) mem[reg_addr][7:0]  <= reg_wdata[7:0];
      if (reg_be[1]) mem[reg_addr][15:8] <= reg_wdata[15:8];
    end
  end

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic release_bus();
    host_sel_n = 1'b1; host_rd_n = 1'b1; host_wr_n = 1'b1;
    host_rnw = 1'b1; host_ds_in_n = 1'b1; host_ds_out_n = 1'b1;
  endtask

  // One host access. Pins of the unused convention are driven as decoys (R3, R4).
  task automatic access(input bit is_wr, input logic [ADDR_W-1:0] a,
                        input logic [DATA_W-1:0] wd, output logic [DATA_W-1:0] rd);
    int w;
    int rd0, wr0;
    rd0 = rd_pulses; wr0 = wr_pulses;
    @(negedge clk);
    host_addr = a; host_data_i = wd; host_sel_n = 1'b0;
    if (cfg_common_strobe) begin
      host_rnw = !is_wr;
      if (is_wr) begin host_ds_in_n = 1'b0; host_ds_out_n = 1'b0; host_rd_n = 1'b0; end
      else       begin host_ds_out_n = 1'b0; host_wr_n = 1'b0; end
    end else begin
      if (is_wr) begin host_wr_n = 1'b0; host_rnw = 1'b1; host_ds_out_n = 1'b0; end
      else       begin host_rd_n = 1'b0; host_rnw = 1'b0; host_ds_in_n = 1'b0; end
    end
    w = 0;
    while (!host_rdy && w < 12) begin
      @(negedge clk);
      w++;
      if (!host_rdy) check("R11 oe before ready", host_data_oe, 0);
    end
    check("R7 ready reached", host_rdy, 1);
    check("R7 ack inverse", host_ack_n, !host_rdy);
    check("R11 oe during access", host_data_oe, !is_wr);
    rd = host_data_o;
    repeat (4) @(negedge clk);
    check("R8 ready held", host_rdy, 1);
    release_bus();
    w = 0;
    while (host_rdy && w < 8) begin @(negedge clk); w++; end
    check("R8 ready removed", host_rdy, 0);
    check("R11 oe removed", host_data_oe, 0);
    check("R7 ack removed", host_ack_n, 1);
    check("R6 read pulses", rd_pulses - rd0, is_wr ? 0 : 1);
    check("R6 write pulses", wr_pulses - wr0, is_wr ? 1 : 0);
    @(negedge clk);
  endtask

  // Stimulus expected to do nothing (R2, R5)
  task automatic quiet(input string req);
    int rd0, wr0;
    rd0 = rd_pulses; wr0 = wr_pulses;
    repeat (10) @(negedge clk);
    check({req, " no ready"}, host_rdy, 0);
    check({req, " no oe"}, host_data_oe, 0);
    check({req, " no strobes"}, (rd_pulses - rd0) + (wr_pulses - wr0), 0);
    release_bus();
    repeat (4) @(negedge clk);
  endtask

  function automatic logic [DATA_W-1:0] pattern(input int a, input int cfg);
    logic [DATA_W-1:0] v;
    v = 16'hC3A5 ^ DATA_W'(a * 16'h0911) ^ DATA_W'(cfg * 16'h5A00);
    return v;
  endfunction

  initial begin
    logic [DATA_W-1:0] got, exp;
    for (int i = 0; i < NREG; i++) begin mem[i] = '0; shadow[i] = '0; end
    repeat (3) @(negedge clk);
    // R1 reset state
    check("R1 ready", host_rdy, 0);
    check("R1 ack", host_ack_n, 1);
    check("R1 oe", host_data_oe, 0);
    check("R1 strobes", {reg_rd, reg_wr}, 0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);

    for (int cfg = 0; cfg < 4; cfg++) begin
      cfg_common_strobe = cfg[0];
      cfg_wide = cfg[1];
      @(negedge clk);
      for (int a = 0; a < 32; a++) begin
        logic [DATA_W-1:0] d;
        d = pattern(a, cfg);
        access(1'b1, ADDR_W'(a), d, got);
        if (cfg_wide) shadow[a >> 1] = d;                        // R9
        else if (a[0]) shadow[a >> 1][15:8] = d[7:0];            // R10
        else shadow[a >> 1][7:0] = d[7:0];
      end
      for (int a = 0; a < 32; a++) begin
        access(1'b0, ADDR_W'(a), 16'hFFFF, got);
        if (cfg_wide) exp = shadow[a >> 1];
        else exp = {8'h00, a[0] ? shadow[a >> 1][15:8] : shadow[a >> 1][7:0]};
        check(cfg_wide ? "R9 wide readback" : "R10 byte readback", got, exp);
        check(cfg[0] ? "R4 common mode data" : "R3 separate mode data", got, exp);
      end
    end

    // R2 deselected strobes in both conventions
    cfg_common_strobe = 1'b0;
    @(negedge clk);
    host_rd_n = 1'b0; host_wr_n = 1'b0;
    quiet("R2 separate deselected");
    cfg_common_strobe = 1'b1;
    @(negedge clk);
    host_rnw = 1'b0; host_ds_in_n = 1'b0; host_ds_out_n = 1'b0;
    quiet("R2 common deselected");
    // R5 output strobe with write direction, input strobe held high
    host_sel_n = 1'b0; host_rnw = 1'b0; host_ds_out_n = 1'b0; host_ds_in_n = 1'b1;
    quiet("R5 blocked write");
    // R5 registers unchanged after the blocked attempt
    cfg_wide = 1'b1;
    for (int r = 0; r < NREG; r++) begin
      access(1'b0, ADDR_W'(r << 1), '0, got);
      check("R5 contents intact", got, shadow[r]);
    end

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    wait (cycles >= 150000);
    errors++;
    $display("FAIL watchdog actual=%0d expected=<150000", cycles);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule